// File: doc/BRIEF.md
# Standby Power Mode Controller

This block turns a 2-bit operating-mode value into the power-state controls of a timing and signal-processing device. It decides whether the digital output drivers run, whether the crystal oscillator is on, and when the timing core gets its reset pulse. In the two lighter standby levels and in full power, a separate output-control vector chooses which driver groups are on. In the deepest standby level the mode overrides that vector and turns every driver off.

The deepest standby level also stops the oscillator. When software leaves that level, the block counts a settle interval on an always-on slow reference clock, which is also the block's own clock. Only after that interval does it pulse the timing-core reset, and then it raises its ready flag. Mode writes that arrive while this sequence runs are held back, and only the newest one is applied when the sequence ends.

Top module: `stby_ctrl`

## Requirements
- R1: The mode value selects the standby level: 00 is full power, 01 is standby 1, 10 is standby 2 and 11 is standby 3. `stby_lvl` is 000 for 00, 001 for 01, 010 for 10 and 100 for 11. A write made while `ready` is high takes effect at the clock edge that samples it.
- R2: While `ready` is high and the mode is 00, 01 or 10, `drv_en[i]` equals the inverse of `outctl[i]`, so a 1 in `outctl` turns that group off. `drv_off` is 0 in this case.
- R3: In standby 3, and whenever `ready` is low, `drv_en` is all zeros and `drv_off` is 1, whatever the value of `outctl`.
- R4: `osc_en` goes low at the edge that applies a write of 11. It stays low until the edge that samples a write of 00, 01 or 10. A write of 11 made during standby 3 has no effect.
- R5: Let E0 be the edge that samples the write leaving standby 3. `core_rst` is high from edge E0+SETTLE_CYC until edge E0+SETTLE_CYC+RST_CYC, and is low at all other times.
- R6: `ready` falls at entry to standby 3 and stays low through the settle interval and the reset pulse. It rises at the edge where `core_rst` falls, unless that same edge re-enters standby 3.
- R7: Writes made during the settle interval or the reset pulse are held, and only the most recent one counts. That value is applied at the edge where `core_rst` falls. If the held value is 11, the block goes straight back into standby 3. `stby_lvl` shows the exit value until then.
- R8: After reset the mode is 00, `ready` and `osc_en` are 1, `core_rst` is 0, `stby_lvl` is 000 and `drv_en` follows `outctl` as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value to write |
| outctl | input | N_GRP | Output-control vector; 1 turns a driver group off |
| drv_en | output | N_GRP | Enable for each driver group |
| drv_off | output | 1 | All drivers forced off by the standby sequence |
| osc_en | output | 1 | Crystal oscillator enable |
| core_rst | output | 1 | Timing-core reset pulse |
| ready | output | 1 | Timing core running in a normal or light standby state |
| stby_lvl | output | 3 | One-hot standby level |

## Verification
The bench steps through full power and both light standby levels. In each it applies all 16 output-control patterns, which separates a correct per-bit inversion from a stuck or shifted mapping. The same 16 patterns are then applied in standby 3 to show that the mode overrides them. The exits from standby 3 are checked cycle by cycle with no held write, with one held write, and with two held writes to show that the newer one wins. Further exits cover a held value of 11, which must re-enter standby 3, and a write landing in the last reset cycle; between them these cases separate off-by-one settle counts and a wrong pending-value priority.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    PM_FULL = 2'b00,
    PM_LITE = 2'b01,
    PM_MID  = 2'b10,
    PM_DEEP = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    SQ_RUN,
    SQ_DARK,
    SQ_SETTLE,
    SQ_PULSE
  } seq_e;

  // one-hot standby level for a mode value
  function automatic logic [2:0] lvl_of(pmode_e m);
    logic [2:0] r;
    case (m)
      PM_LITE: r = 3'b001;
      PM_MID:  r = 3'b010;
      PM_DEEP: r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  // true when a zero-based counter sits on the last cycle of a window
  function automatic logic at_last(int unsigned cnt, int unsigned len);
    return (cnt + 1) == len;
  endfunction

endpackage

// File: rtl/stby_mode_reg.sv
module stby_mode_reg
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  seq_e       seq_st,
  input  logic       seq_done,
  output pmode_e     mode_q,
  output logic       go_dark,
  output logic       go_settle
);

  pmode_e wdata_e;
  pmode_e pend_q;
  pmode_e apply_val;
  logic   pend_vld_q;
  logic   run_wr;
  logic   busy_wr;
  logic   late_apply;

  assign wdata_e    = pmode_e'(mode_wdata);
  assign run_wr     = mode_wr && (seq_st == SQ_RUN);
  assign busy_wr    = mode_wr && ((seq_st == SQ_SETTLE) || (seq_st == SQ_PULSE));
  assign go_settle  = mode_wr && (seq_st == SQ_DARK) && (wdata_e != PM_DEEP);
  assign late_apply = seq_done && (busy_wr || pend_vld_q);
  assign apply_val  = busy_wr ? wdata_e : pend_q;
  assign go_dark    = (run_wr && (wdata_e == PM_DEEP)) ||
                      (late_apply && (apply_val == PM_DEEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_FULL;
    end else if (run_wr || go_settle) begin
      mode_q <= wdata_e;
    end else if (late_apply) begin
      mode_q <= apply_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      pend_q     <= PM_FULL;
    end else if (seq_done) begin
      pend_vld_q <= 1'b0;
    end else if (busy_wr) begin
      pend_vld_q <= 1'b1;
      pend_q     <= wdata_e;
    end
  end

  // R7: no held write survives past the end of the sequence
  p_pend_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !pend_vld_q);

endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 17,
  parameter int unsigned RST_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_dark,
  input  logic go_settle,
  output seq_e st_q,
  output logic seq_done
);

  localparam int unsigned CNT_MAX = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  seq_e          st_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          settle_end;

  assign settle_end = (st_q == SQ_SETTLE) && at_last(32'(cnt_q), SETTLE_CYC);
  assign seq_done   = (st_q == SQ_PULSE) && at_last(32'(cnt_q), RST_CYC);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_RUN: begin
        if (go_dark) st_d = SQ_DARK;
      end
      SQ_DARK: begin
        if (go_settle) begin
          st_d  = SQ_SETTLE;
          cnt_d = '0;
        end
      end
      SQ_SETTLE: begin
        if (settle_end) begin
          st_d  = SQ_PULSE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (seq_done) begin
          st_d  = go_dark ? SQ_DARK : SQ_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // checker: independent count of the cycles spent settling
  logic [CW-1:0] chk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= '0;
    end else if (st_q == SQ_DARK) begin
      chk_q <= '0;
    end else if ((st_q == SQ_SETTLE) && (32'(chk_q) < CNT_MAX)) begin
      chk_q <= chk_q + 1'b1;
    end
  end

  // R5: the reset pulse never starts before the full settle interval
  p_settle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_PULSE) && ($past(st_q) == SQ_SETTLE)) |-> (32'(chk_q) == SETTLE_CYC));

  // R4: settling can only start from the dark state
  p_settle_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_SETTLE) && ($past(st_q) != SQ_SETTLE)) |-> ($past(st_q) == SQ_DARK));

endmodule

// File: rtl/stby_out_map.sv
module stby_out_map
  import stby_pkg::*;
#(
  parameter int unsigned N_GRP = 4
) (
  input  pmode_e            mode_q,
  input  seq_e              st_q,
  input  logic [N_GRP-1:0]  outctl,
  output logic [N_GRP-1:0]  drv_en,
  output logic              drv_off,
  output logic              osc_en,
  output logic              core_rst,
  output logic              ready,
  output logic [2:0]        stby_lvl
);

  logic run;
  logic ctl_owns;

  assign run      = (st_q == SQ_RUN);
  // output control wins in full power and the light standby levels only
  assign ctl_owns = run && (mode_q != PM_DEEP);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign drv_en[g] = ctl_owns && !outctl[g];
  end

  assign drv_off  = !ctl_owns;
  assign osc_en   = (st_q != SQ_DARK);
  assign core_rst = (st_q == SQ_PULSE);
  assign ready    = run;
  assign stby_lvl = lvl_of(mode_q);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned N_GRP      = 4,
  parameter int unsigned SETTLE_CYC = 17,
  parameter int unsigned RST_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic [N_GRP-1:0] outctl,
  output logic [N_GRP-1:0] drv_en,
  output logic             drv_off,
  output logic             osc_en,
  output logic             core_rst,
  output logic             ready,
  output logic [2:0]       stby_lvl
);

  pmode_e mode_q;
  seq_e   st_q;
  logic   seq_done;
  logic   go_dark;
  logic   go_settle;

  stby_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .seq_st     (st_q),
    .seq_done   (seq_done),
    .mode_q     (mode_q),
    .go_dark    (go_dark),
    .go_settle  (go_settle)
  );

  stby_seq #(
    .SETTLE_CYC (SETTLE_CYC),
    .RST_CYC    (RST_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_dark   (go_dark),
    .go_settle (go_settle),
    .st_q      (st_q),
    .seq_done  (seq_done)
  );

  stby_out_map #(
    .N_GRP (N_GRP)
  ) u_map (
    .mode_q   (mode_q),
    .st_q     (st_q),
    .outctl   (outctl),
    .drv_en   (drv_en),
    .drv_off  (drv_off),
    .osc_en   (osc_en),
    .core_rst (core_rst),
    .ready    (ready),
    .stby_lvl (stby_lvl)
  );

  // R3: with the oscillator stopped every driver is off
  p_dark_drv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> ((drv_en == '0) && drv_off));

  // R1: the oscillator is only stopped in standby 3
  p_dark_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (stby_lvl == 3'b100));

  // R4: the core is never reset without a running oscillator
  p_rst_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> osc_en);

  // R6: end of the reset pulse brings ready, or a direct return to standby 3
  p_ready_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (ready || !osc_en));

endmodule

// File: tb/stby_ctrl_bench.sv
module stby_ctrl_bench;

  localparam int N  = 4;
  localparam int S  = 6;
  localparam int RC = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_wr = 1'b0;
  logic [1:0]   mode_wdata = 2'b00;
  logic [N-1:0] outctl = '0;
  logic [N-1:0] drv_en;
  logic         drv_off;
  logic         osc_en;
  logic         core_rst;
  logic         ready;
  logic [2:0]   stby_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  stby_ctrl #(.N_GRP(N), .SETTLE_CYC(S), .RST_CYC(RC)) u_stby_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .outctl(outctl), .drv_en(drv_en), .drv_off(drv_off), .osc_en(osc_en),
    .core_rst(core_rst), .ready(ready), .stby_lvl(stby_lvl)
  );

  function automatic int exp_lvl(int m);
    return (m == 0) ? 0 : (1 << (m - 1));
  endfunction

  task automatic check(int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_mode(int v);
    @(negedge clk);
    mode_wr = 1'b1;
    mode_wdata = 2'(v);
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // sweep all output-control patterns in a running mode
  task automatic sweep_run(int m);
    for (int oc = 0; oc < 16; oc++) begin
      outctl = 4'(oc);
      #1;
      check(int'(drv_en), (~oc) & 15, "R2 drv_en");
      check(int'(drv_off), 0, "R2 drv_off");
      check(int'(stby_lvl), exp_lvl(m), "R1 stby_lvl");
      check(int'(ready), 1, "R6 ready");
      check(int'(osc_en), 1, "R4 osc_en");
    end
  endtask

  task automatic sweep_dark();
    for (int oc = 0; oc < 16; oc++) begin
      outctl = 4'(oc);
      #1;
      check(int'(drv_en), 0, "R3 drv_en");
      check(int'(drv_off), 1, "R3 drv_off");
      check(int'(osc_en), 0, "R4 osc_en");
      check(int'(ready), 0, "R6 ready");
      check(int'(stby_lvl), 4, "R1 stby_lvl");
    end
  endtask

  // leave standby 3 with value ev; optional held writes at offsets k1, k2
  task automatic exit_seq(int ev, int k1, int v1, int k2, int v2);
    int fin;
    fin = ev;
    if (k1 >= 0) fin = v1;
    if (k2 >= 0) fin = v2;
    outctl = 4'b0000;
    @(negedge clk);
    mode_wr = 1'b1;
    mode_wdata = 2'(ev);
    for (int k = 0; k <= S + RC; k++) begin
      @(negedge clk);
      mode_wr = 1'b0;
      check(int'(core_rst), ((k >= S) && (k < S + RC)) ? 1 : 0, "R5 core_rst");
      if (k < S + RC) begin
        check(int'(ready), 0, "R6 ready low");
        check(int'(osc_en), 1, "R4 osc_en on");
        check(int'(drv_en), 0, "R3 drv_en busy");
        check(int'(stby_lvl), exp_lvl(ev), "R7 exit level");
      end else if (fin == 3) begin
        check(int'(ready), 0, "R7 ready");
        check(int'(osc_en), 0, "R7 osc_en");
        check(int'(stby_lvl), 4, "R7 stby_lvl");
      end else begin
        check(int'(ready), 1, "R6 ready high");
        check(int'(stby_lvl), exp_lvl(fin), "R7 stby_lvl");
        check(int'(drv_en), 15, "R2 drv_en after");
      end
      if (k == k1) begin
        mode_wr = 1'b1;
        mode_wdata = 2'(v1);
      end
      if (k == k2) begin
        mode_wr = 1'b1;
        mode_wdata = 2'(v2);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(int'(ready), 1, "R8 ready");
    check(int'(osc_en), 1, "R8 osc_en");
    check(int'(core_rst), 0, "R8 core_rst");
    check(int'(stby_lvl), 0, "R8 stby_lvl");
    check(int'(drv_en), 15, "R8 drv_en");
    sweep_run(0);
    for (int m = 1; m < 3; m++) begin
      wr_mode(m);
      sweep_run(m);
    end
    wr_mode(0);
    sweep_run(0);
    wr_mode(3);
    sweep_dark();
    wr_mode(3);
    sweep_dark();
    exit_seq(0, -1, 0, -1, 0);
    sweep_run(0);
    wr_mode(3);
    exit_seq(1, 2, 2, -1, 0);
    sweep_run(2);
    wr_mode(3);
    exit_seq(2, 1, 1, 5, 0);
    sweep_run(0);
    wr_mode(3);
    exit_seq(1, 4, 3, -1, 0);
    sweep_dark();
    exit_seq(0, S + RC - 1, 1, -1, 0);
    sweep_run(1);
    wr_mode(2);
    wr_mode(3);
    exit_seq(2, -1, 0, -1, 0);
    sweep_run(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule